// File: doc/BRIEF.md
# Root Port Error and PME Signalling Unit

This unit sits beside a PCI Express root port and turns received message notifications into two system-level pulses. Upstream logic decodes error and power-management messages from the link and presents each arrival as a one-cycle strobe. There are three error classes (correctable, non-fatal, fatal) and one PME class. Software controls the unit through a small configuration port with two registers. The control register holds four enable bits. The status register holds a sticky PME flag, and software clears that flag by writing 1 to it.

A system-error pulse goes out when an error message arrives and its class is enabled. Non-fatal and fatal errors also need the command-register SERR enable, which enters the unit as a level input. Correctable errors ignore that gate. A PME interrupt pulse goes out when a PME message arrives while the PME interrupt enable is on. A PME interrupt pulse also goes out when software turns that enable on while the PME flag is already set. Both outputs are registered, single-cycle pulses.

Top module: `rp_err_pme_sig`

## Requirements
- R1: While `rst` is 1 at a clock edge, every enable bit, the PME flag, `sys_err` and `pme_irq` become 0. After reset, both registers read 0x00000000.
- R2: The control register is at address `CTRL_OFS` (default 0x10). Bit 3 enables the PME interrupt, bit 2 the fatal class, bit 1 the non-fatal class and bit 0 the correctable class. These four bits are written from `cfg_wdata[3:0]` and read back. Bits 31..4 always read 0, and writing them has no effect.
- R3: A `msg_pme` strobe sets the PME flag at the next edge, whatever the enable bits hold. The flag reads back on bit 0 of the status register at address `STAT_OFS` (default 0x14). Bits 31..1 of that register read 0.
- R4: Writing a 1 to status bit 0 clears the PME flag at the next edge. Writing a 0 to status bit 0 leaves the flag unchanged.
- R5: When a `msg_pme` strobe and a clearing write to the status register occur in the same cycle, the PME flag is 1 afterwards.
- R6: A `msg_pme` strobe in a cycle where the PME interrupt enable is 1 gives `pme_irq` = 1 on the following cycle. With the enable at 0, no `pme_irq` pulse follows.
- R7: A write that changes the PME interrupt enable from 0 to 1 gives `pme_irq` = 1 on the following cycle if the PME flag was already set. It also gives that pulse if a `msg_pme` strobe arrives in the same cycle as the write.
- R8: A `msg_fatal` strobe gives `sys_err` = 1 on the following cycle only if control bit 2 and `serr_en` are both 1.
- R9: A `msg_nonfatal` strobe gives `sys_err` = 1 on the following cycle only if control bit 1 and `serr_en` are both 1.
- R10: A `msg_cor` strobe gives `sys_err` = 1 on the following cycle whenever control bit 0 is 1, whatever the value of `serr_en`.
- R11: `sys_err` and `pme_irq` are pulses one cycle long. Each is 1 only in the cycle after a qualifying strobe or write. Error gating uses the enable values held before any control write in the same cycle.
- R12: A read from any address other than the two register addresses returns 0. A write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (8) | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational on `cfg_addr` |
| msg_cor | input | 1 | Correctable error message received (one-cycle strobe) |
| msg_nonfatal | input | 1 | Non-fatal error message received (one-cycle strobe) |
| msg_fatal | input | 1 | Fatal error message received (one-cycle strobe) |
| msg_pme | input | 1 | PME message received (one-cycle strobe) |
| serr_en | input | 1 | Command-register SERR enable level |
| sys_err | output | 1 | System-error pulse |
| pme_irq | output | 1 | PME interrupt pulse |

## Verification
Both output pulses fall exactly one edge after the strobe or write that causes them. Register state is visible on `cfg_rdata` as soon as the edge that updates it has passed.

The bench drives each cycle's inputs at the falling edge and computes that cycle's expected pulses from its own model of the enables and the PME flag. It pushes the expected pulses into a queue. It pops the queue and compares the result one time unit after the following rising edge.

Readbacks are compared combinationally in the same settled window. That window falls before the next falling edge changes the inputs, so no sample lands on an edge.

// File: rtl/rp_sig_pkg.sv
package rp_sig_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_CLS = 3;

    // Error class index, matching control bit positions 0..2.
    typedef enum int {
        CLS_COR = 0,
        CLS_NF  = 1,
        CLS_FAT = 2
    } err_cls_e;

    // Classes that skip the command-register SERR gate.
    localparam logic [NUM_CLS-1:0] SERR_BYPASS = 3'b001;

    localparam int PME_EN_BIT = 3;
    localparam int CTRL_BITS  = 4;

    typedef struct packed {
        logic               pme_en;
        logic [NUM_CLS-1:0] err_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.pme_en = w[PME_EN_BIT];
        c.err_en = w[NUM_CLS-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CTRL_BITS-1:0] = c;
        return w;
    endfunction

endpackage

// File: rtl/rp_ctrl_reg.sv
module rp_ctrl_reg
    import rp_sig_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output ctrl_t             ctrl_q,
    output logic              pme_en_rise
);

    ctrl_t ctrl_d;
    logic  hit;

    assign hit = wr_en && (addr == CTRL_OFS);

    always_comb begin
        ctrl_d = ctrl_q;
        if (hit) begin
            ctrl_d = ctrl_from_word(wdata);
        end
    end

    // Enable goes 0 -> 1 at the coming edge.
    assign pme_en_rise = ctrl_d.pme_en && !ctrl_q.pme_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/rp_pme_tracker.sv
module rp_pme_tracker
    import rp_sig_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              msg_pme,
    input  logic              pme_en,
    input  logic              pme_en_rise,
    output logic              pme_stat,
    output logic              pme_irq
);

    logic clr;
    logic stat_d;
    logic irq_d;

    assign clr = wr_en && (addr == STAT_OFS) && wdata[0];

    always_comb begin
        stat_d = pme_stat;
        if (clr) begin
            stat_d = 1'b0;
        end
        if (msg_pme) begin
            stat_d = 1'b1;
        end
    end

    assign irq_d = (msg_pme && pme_en) || (pme_en_rise && (pme_stat || msg_pme));

    always_ff @(posedge clk) begin
        if (rst) begin
            pme_stat <= 1'b0;
            pme_irq  <= 1'b0;
        end else begin
            pme_stat <= stat_d;
            pme_irq  <= irq_d;
        end
    end

endmodule

// File: rtl/rp_err_gate.sv
module rp_err_gate
    import rp_sig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CLS-1:0] msg,
    input  logic [NUM_CLS-1:0] err_en,
    input  logic               serr_en,
    output logic               sys_err
);

    logic [NUM_CLS-1:0] hit;

    for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
        if (SERR_BYPASS[i]) begin : g_bypass
            assign hit[i] = msg[i] && err_en[i];
        end else begin : g_gated
            assign hit[i] = msg[i] && err_en[i] && serr_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_err <= 1'b0;
        end else begin
            sys_err <= |hit;
        end
    end

endmodule

// File: rtl/rp_err_pme_sig.sv
module rp_err_pme_sig
    import rp_sig_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              msg_cor,
    input  logic              msg_nonfatal,
    input  logic              msg_fatal,
    input  logic              msg_pme,
    input  logic              serr_en,
    output logic              sys_err,
    output logic              pme_irq
);

    ctrl_t              ctrl_q;
    logic               pme_en_rise;
    logic               pme_stat;
    logic [NUM_CLS-1:0] msg_vec;

    rp_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr_en),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .ctrl_q      (ctrl_q),
        .pme_en_rise (pme_en_rise)
    );

    rp_pme_tracker #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS)
    ) u_pme (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr_en),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .msg_pme     (msg_pme),
        .pme_en      (ctrl_q.pme_en),
        .pme_en_rise (pme_en_rise),
        .pme_stat    (pme_stat),
        .pme_irq     (pme_irq)
    );

    always_comb begin
        msg_vec          = '0;
        msg_vec[CLS_COR] = msg_cor;
        msg_vec[CLS_NF]  = msg_nonfatal;
        msg_vec[CLS_FAT] = msg_fatal;
    end

    rp_err_gate u_err (
        .clk     (clk),
        .rst     (rst),
        .msg     (msg_vec),
        .err_en  (ctrl_q.err_en),
        .serr_en (serr_en),
        .sys_err (sys_err)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTRL_OFS) begin
            cfg_rdata = ctrl_to_word(ctrl_q);
        end else if (cfg_addr == STAT_OFS) begin
            cfg_rdata[0] = pme_stat;
        end
    end

endmodule

// File: rtl/rp_err_pme_sig_chk.sv
module rp_err_pme_sig_chk #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              msg_cor,
    input logic              msg_nonfatal,
    input logic              msg_fatal,
    input logic              msg_pme,
    input logic              serr_en,
    input logic              sys_err,
    input logic              pme_irq,
    input logic [3:0]        ctrl_bits,
    input logic              pme_stat
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == CTRL_OFS) |-> (cfg_rdata[31:4] == 28'h0));

    a_r5_pme_sets_flag: assert property (@(posedge clk) disable iff (rst)
        msg_pme |=> pme_stat);

    a_r4_clear_flag: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_addr == STAT_OFS && cfg_wdata[0] && !msg_pme) |=> !pme_stat);

    a_r7_enable_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_bits[3]) && $past(pme_stat)) |-> pme_irq);

    a_r6_pme_irq: assert property (@(posedge clk) disable iff (rst)
        (msg_pme && ctrl_bits[3]) |=> pme_irq);

    a_r8_fatal: assert property (@(posedge clk) disable iff (rst)
        (msg_fatal && ctrl_bits[2] && serr_en) |=> sys_err);

    a_r9_nonfatal: assert property (@(posedge clk) disable iff (rst)
        (msg_nonfatal && ctrl_bits[1] && serr_en) |=> sys_err);

    a_r10_correctable: assert property (@(posedge clk) disable iff (rst)
        (msg_cor && ctrl_bits[0]) |=> sys_err);

    a_r11_no_err_strobe: assert property (@(posedge clk) disable iff (rst)
        (!msg_cor && !msg_nonfatal && !msg_fatal) |=> !sys_err);

    a_r11_no_pme_cause: assert property (@(posedge clk) disable iff (rst)
        (!msg_pme && !(cfg_wr_en && cfg_addr == CTRL_OFS && cfg_wdata[3])) |=> !pme_irq);

endmodule

bind rp_err_pme_sig rp_err_pme_sig_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .STAT_OFS (STAT_OFS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .msg_cor      (msg_cor),
    .msg_nonfatal (msg_nonfatal),
    .msg_fatal    (msg_fatal),
    .msg_pme      (msg_pme),
    .serr_en      (serr_en),
    .sys_err      (sys_err),
    .pme_irq      (pme_irq),
    .ctrl_bits    (ctrl_q),
    .pme_stat     (pme_stat)
);

// File: tb/sim_rp_err_pme_sig.sv
`timescale 1ns/1ps
module sim_rp_err_pme_sig;

    localparam logic [7:0] CTRL = 8'h10;
    localparam logic [7:0] STAT = 8'h14;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        msg_cor, msg_nonfatal, msg_fatal, msg_pme, serr_en;
    logic        sys_err, pme_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic  sys;
        logic  irq;
        string tag;
    } exp_t;

    exp_t sb[$];

    logic [3:0] m_ctrl;
    logic       m_stat;

    always #2.5 clk = ~clk;

    rp_err_pme_sig u0 (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .msg_cor      (msg_cor),
        .msg_nonfatal (msg_nonfatal),
        .msg_fatal    (msg_fatal),
        .msg_pme      (msg_pme),
        .serr_en      (serr_en),
        .sys_err      (sys_err),
        .pme_irq      (pme_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item and compares the registered outputs.
    task automatic monitor_pop();
        exp_t e;
        e = sb.pop_front();
        check_val({e.tag, " sys_err"}, {31'b0, sys_err}, {31'b0, e.sys});
        check_val({e.tag, " pme_irq"}, {31'b0, pme_irq}, {31'b0, e.irq});
    endtask

    // Driver: applies one cycle of stimulus, pushes the model's expectation.
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic c, input logic nf, input logic f, input logic p,
                        input logic se, input string tag);
        exp_t e;
        logic rise;
        @(negedge clk);
        cfg_wr_en = wr; cfg_addr = a; cfg_wdata = d;
        msg_cor = c; msg_nonfatal = nf; msg_fatal = f; msg_pme = p; serr_en = se;
        rise  = wr && (a == CTRL) && d[3] && !m_ctrl[3];
        e.sys = (c && m_ctrl[0]) || (se && ((nf && m_ctrl[1]) || (f && m_ctrl[2])));
        e.irq = (p && m_ctrl[3]) || (rise && (m_stat || p));
        e.tag = tag;
        sb.push_back(e);
        if (wr && a == CTRL) m_ctrl = d[3:0];
        if (p) m_stat = 1'b1;
        else if (wr && a == STAT && d[0]) m_stat = 1'b0;
        @(posedge clk);
        #1;
        monitor_pop();
        cfg_wr_en = 1'b0;
        msg_cor = 1'b0; msg_nonfatal = 1'b0; msg_fatal = 1'b0; msg_pme = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cfg_wr_en = 1'b0;
        cfg_addr  = a;
        #0.5;
        check_val(tag, cfg_rdata, exp);
    endtask

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        msg_cor = 1'b0; msg_nonfatal = 1'b0; msg_fatal = 1'b0; msg_pme = 1'b0;
        serr_en = 1'b0;
        m_ctrl = '0; m_stat = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_val("R1 sys_err", {31'b0, sys_err}, 32'h0);
        check_val("R1 pme_irq", {31'b0, pme_irq}, 32'h0);
        rd_check(CTRL, 32'h0, "R1 ctrl");
        rd_check(STAT, 32'h0, "R1 stat");
        @(negedge clk);
        rst = 1'b0;

        // R2: enable bits read back, reserved bits ignored
        step(1, CTRL, 32'hFFFF_FFF5, 0, 0, 0, 0, 0, "R2 write");
        rd_check(CTRL, 32'h5, "R2 readback");
        step(1, CTRL, 32'h0000_000A, 0, 0, 0, 0, 0, "R2 write2");
        rd_check(CTRL, 32'hA, "R2 readback2");
        step(1, CTRL, 32'h0, 0, 0, 0, 0, 0, "R2 clear");

        // R10: correctable independent of SERR
        step(1, CTRL, 32'h1, 0, 0, 0, 0, 0, "R10 en");
        step(0, 8'h0, 0, 1, 0, 0, 0, 0, "R10 serr0");
        step(0, 8'h0, 0, 1, 0, 0, 0, 1, "R10 serr1");
        step(0, 8'h0, 0, 0, 1, 1, 0, 1, "R10 other classes off");
        step(0, 8'h0, 0, 0, 0, 0, 0, 1, "R11 idle");

        // R8 / R9: gated by class bit and SERR
        step(1, CTRL, 32'h6, 0, 0, 0, 0, 0, "R8 en");
        step(0, 8'h0, 0, 0, 0, 1, 0, 0, "R8 serr off");
        step(0, 8'h0, 0, 0, 0, 1, 0, 1, "R8 serr on");
        step(0, 8'h0, 0, 0, 1, 0, 0, 0, "R9 serr off");
        step(0, 8'h0, 0, 0, 1, 0, 0, 1, "R9 serr on");
        step(0, 8'h0, 0, 1, 0, 0, 0, 1, "R10 cor disabled");
        step(1, CTRL, 32'h2, 0, 0, 0, 0, 1, "R9 only nf");
        step(0, 8'h0, 0, 0, 0, 1, 0, 1, "R8 fat disabled");
        step(0, 8'h0, 0, 0, 1, 0, 0, 1, "R9 nf enabled");
        // R11: same-cycle write uses old enables
        step(1, CTRL, 32'h0, 0, 1, 0, 0, 1, "R11 old enable used");
        step(0, 8'h0, 0, 0, 1, 0, 0, 1, "R11 new enable used");
        step(0, 8'h0, 0, 0, 0, 0, 0, 1, "R11 pulse ends");

        // R3 / R6: PME with enable off sets flag, no interrupt
        step(0, 8'h0, 0, 0, 0, 0, 1, 0, "R6 disabled");
        rd_check(STAT, 32'h1, "R3 flag set");
        // R4: write 0 keeps, write 1 clears
        step(1, STAT, 32'hFFFF_FFFE, 0, 0, 0, 0, 0, "R4 write0");
        rd_check(STAT, 32'h1, "R4 write0 keeps");
        step(1, STAT, 32'h1, 0, 0, 0, 0, 0, "R4 write1");
        rd_check(STAT, 32'h0, "R4 cleared");
        // R5: message wins over clear
        step(1, STAT, 32'h1, 0, 0, 0, 1, 0, "R5 race");
        rd_check(STAT, 32'h1, "R5 flag kept");
        // R7: enable rise with flag set
        step(1, CTRL, 32'h8, 0, 0, 0, 0, 0, "R7 rise with flag");
        step(1, CTRL, 32'h8, 0, 0, 0, 0, 0, "R7 no second rise");
        // R6: message with enable on
        step(0, 8'h0, 0, 0, 0, 0, 1, 0, "R6 enabled");
        step(0, 8'h0, 0, 0, 0, 0, 0, 0, "R11 irq pulse ends");
        // R7: rise without flag, then rise with same-cycle message
        step(1, CTRL, 32'h0, 0, 0, 0, 0, 0, "R7 disable");
        step(1, STAT, 32'h1, 0, 0, 0, 0, 0, "R7 clear flag");
        step(1, CTRL, 32'h8, 0, 0, 0, 0, 0, "R7 rise no flag");
        step(1, CTRL, 32'h0, 0, 0, 0, 0, 0, "R7 disable2");
        step(1, STAT, 32'h1, 0, 0, 0, 0, 0, "R7 clear2");
        step(1, CTRL, 32'h8, 0, 0, 0, 1, 0, "R7 rise with message");

        // R12: unmapped address
        step(1, 8'h20, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R12 write");
        rd_check(8'h20, 32'h0, "R12 read zero");
        rd_check(CTRL, 32'h8, "R12 ctrl untouched");
        rd_check(STAT, 32'h1, "R12 stat untouched");

        // R1: reset mid-run clears state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rd_check(CTRL, 32'h0, "R1 ctrl after reset");
        rd_check(STAT, 32'h0, "R1 stat after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule